// File: doc/BRIEF.md
# Dual-Line Grouped Interrupt Controller

This block gathers a wide vector of interrupt inputs (224 by default), organised as seven groups of 32 sources, and condenses them onto two interrupt lines, EXT0 and EXT1, that feed a parent controller. Source n sits at bit n%32 of group word n/32. Each source is configured independently. A trigger-type bit selects edge or level sensing. A polarity bit selects the active sense. A route bit picks which of the two lines the source drives. An enable bit decides whether the source is seen at all. Every input passes through a two-flop synchroniser before any detection is done.

Edge events are held as pending until software writes a one to the matching clear bit. Level sources show their qualified input directly. For each line the block publishes a masked status word per group. A single summary word lets a handler find the groups with work, walk into the matching status word, and then clear the source.

Access uses a plain synchronous register port with two windows, chosen by `reg_win`, and a 5-bit word index; the byte offset is four times the index. The port has no back-pressure. A write completes in the cycle `reg_en` and `reg_we` are sampled high. Read data appears on `reg_rdata` in the cycle after `reg_en` is sampled with `reg_we` low, and is zero otherwise. The interrupt inputs and the two lines are plain level signals.

Top module: `dual_line_irq_ctrl`

## Requirements
- R1: In window 0, word index a*7+g holds group g of configuration array a, with trigger type at a=0, polarity at a=1, route at a=2 and enable at a=3 (byte offsets 0x00, 0x1C, 0x38, 0x54). These words read back what was last written.
- R2: After reset, every configuration word, every status word and the summary read 0, and both lines are low. All sources therefore start disabled, level-sensed and active-high.
- R3: With trigger type 1 (edge), a synchronised 0-to-1 change latches the source pending when polarity is 0, and a 1-to-0 change does so when polarity is 1. The bit stays pending until it is cleared.
- R4: With trigger type 0 (level), the pending state equals the synchronised input XOR polarity. A clear write leaves no lasting effect on it.
- R5: Writing window 1 index g (0..6) clears each edge-mode source of group g whose data bit is 1. Bits written as 0 change nothing, and these words read as 0.
- R6: An enable bit of 0 keeps the source out of both status arrays, the summary and both lines. Its pending state is kept, so it appears once the source is enabled.
- R7: A route bit of 1 places the enabled pending source in the EXT0 status word, at window 1 index 14+g (byte 0x38). A route bit of 0 places it in the EXT1 status word, at index 7+g (byte 0x1C).
- R8: The summary word at window 1 index 31 (byte 0x7C) sets bit g when EXT1 status word g is non-zero, and bit 8+g when EXT0 status word g is non-zero. All other bits read 0.
- R9: Changing polarity or trigger type while an input is steady never creates an edge event.
- R10: If an edge event and a clear of the same source land in the same cycle, the source remains pending.
- R11: `ext0_irq` and `ext1_irq` are registered. Each equals the OR of all its line's status bits, one cycle later.
- R12: Writes to the window 1 status and summary words, and to unused indices, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 224 | Raw interrupt inputs, source n at bit n |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_win | input | 1 | Window select: 0 configuration, 1 clear/status |
| reg_addr | input | 5 | Word index inside the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| ext0_irq | output | 1 | Line EXT0, level |
| ext1_irq | output | 1 | Line EXT1, level |

## Verification
The colliding pair is a freshly synchronised edge on a source and a clear write to that same source, meeting at one clock edge. The bench raises the input, lets two edges pass so that the edge detector is active, and then times the clear write to be sampled on the next edge. The check passes only if the source is still pending in its status word and summary afterwards. Randomised steps also mix clear writes with input toggles and configuration changes, and a reference model in the bench judges every status word, the summary and both lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // configuration arrays in window 0, in address order
  localparam int ARR_TYPE    = 0;
  localparam int ARR_POL     = 1;
  localparam int ARR_ROUTE   = 2;
  localparam int ARR_MASK    = 3;
  localparam int NUM_CFG_ARR = 4;
  // arrays in window 1
  localparam int WIN1_CLEAR  = 0;
  localparam int WIN1_STAT1  = 1;
  localparam int WIN1_STAT0  = 2;
  localparam int SUMMARY_IDX = 31;
  // bit offset of the EXT0 group flags inside the summary word
  localparam int SUM_EXT0_SHIFT = 8;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;
  logic [W-1:0] stage3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      stage3 <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign cur  = stage2;
  assign prev = stage3;
endmodule

// File: rtl/irqc_src_group.sv
module irqc_src_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] cfg_type,
  input  logic [W-1:0] cfg_pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] lvl
);
  logic [W-1:0] cur;
  logic [W-1:0] prev;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] pend_q;

  irqc_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw),
    .cur  (cur),
    .prev (prev)
  );

  // direction is chosen after the sample pair, so a polarity flip alone
  // cannot make an edge
  assign rise     = cur & ~prev;
  assign fall     = ~cur & prev;
  assign edge_hit = cfg_type & ((rise & ~cfg_pol) | (fall & cfg_pol));
  assign lvl      = cur ^ cfg_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      // a new edge overrides a clear in the same cycle
      pend_q <= (cfg_type & (edge_hit | (pend_q & ~clr))) | (~cfg_type & lvl);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int NG = 7,
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic          reg_win,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  input  logic [NG*W-1:0] stat0,
  input  logic [NG*W-1:0] stat1,
  input  logic [W-1:0]  summary,
  output logic [NG*W-1:0] cfg_type,
  output logic [NG*W-1:0] cfg_pol,
  output logic [NG*W-1:0] cfg_route,
  output logic [NG*W-1:0] cfg_mask,
  output logic [NG*W-1:0] clr,
  output logic [W-1:0]  reg_rdata
);
  logic [W-1:0] cfg_q [NUM_CFG_ARR][NG];
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;
  logic         wr_cfg;
  logic         wr_win1;
  logic         rd_any;

  assign wr_cfg  = reg_en & reg_we & ~reg_win;
  assign wr_win1 = reg_en & reg_we & reg_win;
  assign rd_any  = reg_en & ~reg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_CFG_ARR; a++) begin
        for (int g = 0; g < NG; g++) begin
          cfg_q[a][g] <= '0;
        end
      end
    end else if (wr_cfg) begin
      for (int a = 0; a < NUM_CFG_ARR; a++) begin
        for (int g = 0; g < NG; g++) begin
          if (reg_addr == AW'(a * NG + g)) cfg_q[a][g] <= reg_wdata;
        end
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_flat
    assign cfg_type [g*W +: W] = cfg_q[ARR_TYPE][g];
    assign cfg_pol  [g*W +: W] = cfg_q[ARR_POL][g];
    assign cfg_route[g*W +: W] = cfg_q[ARR_ROUTE][g];
    assign cfg_mask [g*W +: W] = cfg_q[ARR_MASK][g];
    assign clr[g*W +: W] =
      (wr_win1 && reg_addr == AW'(WIN1_CLEAR * NG + g)) ? reg_wdata : '0;
  end

  always_comb begin
    rd_mux = '0;
    if (!reg_win) begin
      for (int a = 0; a < NUM_CFG_ARR; a++) begin
        for (int g = 0; g < NG; g++) begin
          if (reg_addr == AW'(a * NG + g)) rd_mux = cfg_q[a][g];
        end
      end
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (reg_addr == AW'(WIN1_STAT1 * NG + g)) rd_mux = stat1[g*W +: W];
        if (reg_addr == AW'(WIN1_STAT0 * NG + g)) rd_mux = stat0[g*W +: W];
      end
      if (reg_addr == AW'(SUMMARY_IDX)) rd_mux = summary;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_any ? rd_mux : '0;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/dual_line_irq_ctrl.sv
module dual_line_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 7,
  parameter int GROUP_W    = 32,
  parameter int ADDR_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0] irq_in,
  input  logic                          reg_en,
  input  logic                          reg_we,
  input  logic                          reg_win,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [GROUP_W-1:0]            reg_wdata,
  output logic [GROUP_W-1:0]            reg_rdata,
  output logic                          ext0_irq,
  output logic                          ext1_irq
);
  localparam int NSRC = NUM_GROUPS * GROUP_W;

  logic [NSRC-1:0]    type_all;
  logic [NSRC-1:0]    pol_all;
  logic [NSRC-1:0]    route_all;
  logic [NSRC-1:0]    mask_all;
  logic [NSRC-1:0]    clr_all;
  logic [NSRC-1:0]    pend_all;
  logic [NSRC-1:0]    set_all;
  logic [NSRC-1:0]    lvl_all;
  logic [NSRC-1:0]    stat0_all;
  logic [NSRC-1:0]    stat1_all;
  logic [GROUP_W-1:0] summary;
  logic               ext0_q;
  logic               ext1_q;

  irqc_regfile #(.NG(NUM_GROUPS), .W(GROUP_W), .AW(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_en   (reg_en),
    .reg_we   (reg_we),
    .reg_win  (reg_win),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .stat0    (stat0_all),
    .stat1    (stat1_all),
    .summary  (summary),
    .cfg_type (type_all),
    .cfg_pol  (pol_all),
    .cfg_route(route_all),
    .cfg_mask (mask_all),
    .clr      (clr_all),
    .reg_rdata(reg_rdata)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqc_src_group #(.W(GROUP_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (irq_in  [g*GROUP_W +: GROUP_W]),
      .cfg_type(type_all[g*GROUP_W +: GROUP_W]),
      .cfg_pol (pol_all [g*GROUP_W +: GROUP_W]),
      .clr     (clr_all [g*GROUP_W +: GROUP_W]),
      .pend    (pend_all[g*GROUP_W +: GROUP_W]),
      .edge_hit(set_all [g*GROUP_W +: GROUP_W]),
      .lvl     (lvl_all [g*GROUP_W +: GROUP_W])
    );
  end

  assign stat0_all = pend_all & mask_all & route_all;
  assign stat1_all = pend_all & mask_all & ~route_all;

  always_comb begin
    summary = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      summary[g]                  = |stat1_all[g*GROUP_W +: GROUP_W];
      summary[SUM_EXT0_SHIFT + g] = |stat0_all[g*GROUP_W +: GROUP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext0_q <= 1'b0;
      ext1_q <= 1'b0;
    end else begin
      ext0_q <= |stat0_all;
      ext1_q <= |stat1_all;
    end
  end

  assign ext0_irq = ext0_q;
  assign ext1_irq = ext1_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSRC = 224,
  parameter int NG   = 7,
  parameter int W    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext0_irq,
  input logic            ext1_irq,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] set_hit,
  input logic [NSRC-1:0] lvl,
  input logic [NSRC-1:0] clr,
  input logic [NSRC-1:0] cfg_type,
  input logic [NSRC-1:0] cfg_mask,
  input logic [NSRC-1:0] stat0,
  input logic [NSRC-1:0] stat1,
  input logic [W-1:0]    summary
);
  localparam logic [W-1:0] GRP_BITS = W'((1 << NG) - 1);
  localparam logic [W-1:0] KEEP     = GRP_BITS | (GRP_BITS << 8);

  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(~cfg_type) & (pend ^ $past(lvl))) == '0));

  p_clear_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & $past(clr & cfg_type & ~set_hit)) == '0));

  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat0 | stat1) & ~cfg_mask) == '0));

  p_route_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat0 & stat1) == '0));

  p_summary_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((summary & ~KEEP) == '0));

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_hit & cfg_type) & ~pend) == '0));

  p_line_ext0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext0_irq == $past(|stat0)));

  p_line_ext1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext1_irq == $past(|stat1)));
endmodule

bind dual_line_irq_ctrl irqc_checker #(
  .NSRC(NSRC), .NG(NUM_GROUPS), .W(GROUP_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ext0_irq(ext0_irq),
  .ext1_irq(ext1_irq),
  .pend    (pend_all),
  .set_hit (set_all),
  .lvl     (lvl_all),
  .clr     (clr_all),
  .cfg_type(type_all),
  .cfg_mask(mask_all),
  .stat0   (stat0_all),
  .stat1   (stat1_all),
  .summary (summary)
);

// File: tb/dual_line_irq_ctrl_tb.sv
module dual_line_irq_ctrl_tb;
  localparam int NG = 7;
  localparam int W  = 32;
  localparam int TYP = 0, POL = 1, RTE = 2, MSK = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*W-1:0] irq_in;
  logic          reg_en = 1'b0, reg_we = 1'b0, reg_win = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          ext0_irq, ext1_irq;

  logic [W-1:0] m_cfg [4][NG];
  logic [W-1:0] m_pend [NG];
  logic [W-1:0] in_w [NG];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int g = 0; g < NG; g++) irq_in[g*W +: W] = in_w[g];
  end

  dual_line_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_en(reg_en), .reg_we(reg_we), .reg_win(reg_win),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext0_irq(ext0_irq), .ext1_irq(ext1_irq)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(input bit win, input int idx, input logic [W-1:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_win = win; reg_addr = 5'(idx); reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic do_read(input bit win, input int idx, output logic [W-1:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_win = win; reg_addr = 5'(idx);
    @(negedge clk);
    d = reg_rdata;
    reg_en = 1'b0;
  endtask

  // model: level sources follow input xor polarity
  task automatic m_level();
    for (int g = 0; g < NG; g++)
      m_pend[g] = (m_pend[g] & m_cfg[TYP][g]) | (~m_cfg[TYP][g] & (in_w[g] ^ m_cfg[POL][g]));
  endtask

  // model: drive a new input word and latch the edges it makes
  task automatic m_inputs(input int g, input logic [W-1:0] nw);
    logic [W-1:0] rise, fall;
    rise = nw & ~in_w[g];
    fall = ~nw & in_w[g];
    m_pend[g] |= m_cfg[TYP][g] & ((rise & ~m_cfg[POL][g]) | (fall & m_cfg[POL][g]));
    in_w[g] = nw;
  endtask

  task automatic cfg_write(input int a, input int g, input logic [W-1:0] d);
    do_write(1'b0, a * NG + g, d);
    m_cfg[a][g] = d;
    repeat (3) @(negedge clk);
    m_level();
  endtask

  task automatic clr_write(input int g, input logic [W-1:0] d);
    do_write(1'b1, g, d);
    m_pend[g] &= ~(d & m_cfg[TYP][g]);
    repeat (2) @(negedge clk);
    m_level();
  endtask

  task automatic set_input(input int g, input logic [W-1:0] nw);
    m_inputs(g, nw);
    repeat (5) @(negedge clk);
    m_level();
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] d, e0, e1, sum;
    bit any0, any1;
    sum = '0; any0 = 1'b0; any1 = 1'b0;
    for (int g = 0; g < NG; g++) begin
      e0 = m_pend[g] & m_cfg[MSK][g] & m_cfg[RTE][g];
      e1 = m_pend[g] & m_cfg[MSK][g] & ~m_cfg[RTE][g];
      do_read(1'b1, 14 + g, d);
      check($sformatf("%s EXT0 status g%0d", tag, g), d, e0);
      do_read(1'b1, 7 + g, d);
      check($sformatf("%s EXT1 status g%0d", tag, g), d, e1);
      do_read(1'b1, g, d);
      check($sformatf("R5 clear word reads zero g%0d", g), d, '0);
      sum[g] = |e1;
      sum[8 + g] = |e0;
      any0 |= |e0;
      any1 |= |e1;
    end
    do_read(1'b1, 31, d);
    check({tag, " R8 summary"}, d, sum);
    check({tag, " R11 ext0 line"}, W'(ext0_irq), W'(any0));
    check({tag, " R11 ext1 line"}, W'(ext1_irq), W'(any1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] tmp [NG];
    void'($urandom(32'h1D5C));
    for (int g = 0; g < NG; g++) begin
      in_w[g] = '0; m_pend[g] = '0;
      for (int a = 0; a < 4; a++) m_cfg[a][g] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    for (int i = 0; i < 4 * NG; i++) begin
      do_read(1'b0, i, d);
      check("R2 config word after reset", d, '0);
    end
    check_all("R2");

    // R3 rising edge on source 5, routed to EXT0
    cfg_write(MSK, 0, 32'h20);
    cfg_write(RTE, 0, 32'h20);
    cfg_write(TYP, 0, 32'h20);
    set_input(0, 32'h20);
    check_all("R3 rise");
    clr_write(0, 32'h0);
    check_all("R5 zero write");
    clr_write(0, 32'h20);
    check_all("R5 clear");
    // R9 polarity flip with steady high input: no event
    cfg_write(POL, 0, 32'h20);
    check_all("R9 pol flip");
    set_input(0, 32'h0);
    check_all("R3 fall");
    clr_write(0, 32'h20);

    // R4 level source 223 on EXT1
    cfg_write(MSK, 6, 32'h8000_0000);
    set_input(6, 32'h8000_0000);
    check_all("R4 level high");
    clr_write(6, 32'h8000_0000);
    check_all("R4 clear ignored");
    set_input(6, 32'h0);
    check_all("R4 level low");
    // R9 mode change with steady input
    cfg_write(TYP, 6, 32'h8000_0000);
    check_all("R9 mode change");

    // R6 disabled edge source 33 keeps pending hidden
    cfg_write(TYP, 1, 32'h2);
    set_input(1, 32'h2);
    check_all("R6 disabled");
    cfg_write(MSK, 1, 32'h2);
    check_all("R6 enabled later");
    clr_write(1, 32'h2);

    // R10 edge and clear in the same cycle on source 40
    cfg_write(TYP, 1, 32'h102);
    cfg_write(MSK, 1, 32'h102);
    @(negedge clk);
    m_inputs(1, in_w[1] | 32'h100);
    @(posedge clk);
    @(posedge clk);
    do_write(1'b1, 1, 32'h100);
    repeat (3) @(negedge clk);
    m_level();
    check_all("R10 edge beats clear");
    clr_write(1, 32'h100);
    check_all("R10 later clear");

    // R12 writes to read-only and unused locations
    do_write(1'b1, 8, 32'hFFFF_FFFF);
    do_write(1'b1, 15, 32'hFFFF_FFFF);
    do_write(1'b1, 31, 32'hFFFF_FFFF);
    do_write(1'b0, 30, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    do_read(1'b0, 30, d);
    check("R12 unused config index", d, '0);
    check_all("R12");

    // constrained random mix
    for (int s = 0; s < 150; s++) begin
      if ($urandom_range(0, 2) == 0)
        cfg_write($urandom_range(0, 3), $urandom_range(0, NG - 1), $urandom);
      for (int g = 0; g < NG; g++) tmp[g] = in_w[g];
      for (int k = 0; k < $urandom_range(1, 4); k++) begin
        int gg = $urandom_range(0, NG - 1);
        tmp[gg][$urandom_range(0, W - 1)] ^= 1'b1;
      end
      for (int g = 0; g < NG; g++) m_inputs(g, tmp[g]);
      repeat (5) @(negedge clk);
      m_level();
      if ($urandom_range(0, 1) == 1)
        clr_write($urandom_range(0, NG - 1), $urandom & $urandom);
      check_all("R3 R4 R7 random");
    end

    // R1 config readback at every index
    for (int a = 0; a < 4; a++)
      for (int g = 0; g < NG; g++) cfg_write(a, g, $urandom);
    for (int a = 0; a < 4; a++)
      for (int g = 0; g < NG; g++) begin
        do_read(1'b0, a * NG + g, d);
        check($sformatf("R1 config a%0d g%0d", a, g), d, m_cfg[a][g]);
      end
    check_all("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule